// File: doc/BRIEF.md
# Audio Ring-Buffer Fetch Engine

This block streams audio payload out of a circular region of system memory into a small local sample queue. Software programs three 32-bit byte addresses: where the ring begins, where fetching resumes, and the address of the final 8-byte word of the ring. The engine then issues fixed-size read bursts of 16 beats of 64 bits (128 bytes), moves the fetch pointer forward after each burst, and returns to the ring base after the burst that ends on the final word. The usable ring length is a whole number of bursts, so a burst never crosses the wrap point.

Fetching is gated by two separate enables, and both must be set. A burst is only requested when the local queue can take a whole burst, so the response channel needs no back-pressure. Raising the init control reloads the fetch pointer from the ring base and holds fetching off until init is released. A synchronous soft reset empties the queue and parks the pointer on the ring base. Pointers are reprogrammed, and soft reset is used, only while no burst is outstanding.

Top module: `aud_ring_fetch`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows mem_req_valid = 0, smp_valid = 0 and rd_ptr = 0.
- R2: A cycle with rd_wr = 1 (and init, soft_rst low) makes rd_ptr equal rd_wdata from the next cycle on.
- R3: A cycle with init = 1 makes rd_ptr equal cfg_start in the next cycle, and no new burst request starts while init is high.
- R4: A new burst request starts only if fill_en and empty_en were both 1 and init was 0 in the cycle before mem_req_valid rises; with either enable low no request is made.
- R5: A request starts only when the queue holds at most FIFO_WORDS - 16 words; its address equals rd_ptr, and mem_req_valid with a stable address stays up until mem_req_ready.
- R6: Each burst takes exactly 16 response beats; after the last beat rd_ptr becomes cfg_start if rd_ptr + 120 equals cfg_end, otherwise rd_ptr + 128.
- R7: smp_data delivers the accepted beats in arrival order; smp_valid is 1 whenever the queue is non-empty, and smp_data holds while smp_valid is 1 and smp_ready is 0.
- R8: A cycle with soft_rst = 1 leaves the queue empty (smp_valid = 0) and rd_ptr = cfg_start in the next cycle.
- R9: Clearing an enable during a burst lets that burst finish with all 16 beats queued, and no further request follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset: empties queue, pointer to ring base |
| init | input | 1 | Reload pointer from ring base; holds fetching off while high |
| fill_en | input | 1 | Fetch enable, first of two |
| empty_en | input | 1 | Fetch enable, second of two |
| cfg_start | input | 32 | Ring base byte address (128-byte aligned) |
| cfg_end | input | 32 | Byte address of the last 8-byte word in the ring |
| rd_wr | input | 1 | Write strobe for the fetch pointer |
| rd_wdata | input | 32 | Value written to the fetch pointer |
| rd_ptr | output | 32 | Current fetch pointer (address of next burst) |
| mem_req_valid | output | 1 | Burst read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Burst start byte address |
| mem_rsp_valid | input | 1 | Response beat valid |
| mem_rsp_data | input | 64 | Response beat data |
| smp_valid | output | 1 | Queue has a sample word |
| smp_ready | input | 1 | Consumer takes the head word |
| smp_data | output | 64 | Head sample word |

## Verification
A request follows one cycle after the conditions that allow it, a queued beat becomes visible at smp_data one cycle after its accepting edge, and rd_ptr changes one cycle after the final beat, after a write strobe, an init cycle or a soft reset. The bench drives inputs a quarter period after the rising edge and reads outputs at mid period, its memory model returns each word's own address as data, so every popped word and every request address is compared against a reference walk of the ring computed from cfg_start and cfg_end. Pointer and queue results are read one full cycle after the causing edge, and request counts are read after long enough quiet windows that no burst can still be pending.

// File: rtl/aud_fetch_pkg.sv
// Shared types for the audio ring-buffer fetch engine.
package aud_fetch_pkg;
    // Fetch sequencer states.
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_REQ   = 2'd1,
        FS_BURST = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/aud_fetch_ptr.sv
// Fetch pointer register.
// Holds the byte address of the next burst. Reloads the ring base on
// load_base, takes a software value on wr, and after a completed burst
// either steps forward by one burst or returns to the base when the burst
// ended on the last word of the ring. Assumes the ring length is a whole
// number of bursts and that the base is burst aligned.
module aud_fetch_ptr #(
    parameter int ADDR_W      = 32,
    parameter int BEAT_BYTES  = 8,
    parameter int BURST_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_base,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wr_val,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] last_word,
    input  logic              advance,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(BURST_BYTES);
    localparam logic [ADDR_W-1:0] LAST_OFS = ADDR_W'(BURST_BYTES - BEAT_BYTES);

    logic              at_wrap;
    logic [ADDR_W-1:0] next_ptr;

    // Decide whether the current burst ends on the ring's last word.
    always_comb begin
        at_wrap  = ((ptr + LAST_OFS) == last_word);
        next_ptr = at_wrap ? base : (ptr + STEP);
    end

    // Pointer update with load priority over write over advance.
    always_ff @(posedge clk) begin
        if (!rst_n)         ptr <= '0;
        else if (load_base) ptr <= base;
        else if (wr)        ptr <= wr_val;
        else if (advance)   ptr <= next_ptr;
    end
endmodule

// File: rtl/aud_fetch_fifo.sv
// Sample queue.
// First-word-fall-through FIFO holding fetched beats for the consumer.
// Assumes DEPTH is a power of two and that the writer never pushes into
// a full queue (the sequencer reserves room before each burst).
module aud_fetch_fifo #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] din,
    input  logic              pop,
    output logic [DATA_W-1:0] dout,
    output logic              not_empty,
    output logic [LVL_W-1:0]  level
);
    logic [DATA_W-1:0] store [DEPTH];
    logic [AW-1:0]     wr_idx;
    logic [AW-1:0]     rd_idx;
    logic              do_push;
    logic              do_pop;

    // Qualify push and pop against the current fill.
    always_comb begin
        do_push   = push && (level != LVL_W'(DEPTH));
        do_pop    = pop && (level != '0);
        not_empty = (level != '0);
        dout      = store[rd_idx];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) store[wr_idx] <= din;
    end

    // Index and fill bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_idx <= '0;
            rd_idx <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_idx <= wr_idx + 1'b1;
            if (do_pop)  rd_idx <= rd_idx + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/aud_fetch_ctrl.sv
// Burst sequencer.
// Starts a burst request when fetching is allowed and the queue has room
// for a whole burst, holds the request until accepted, then counts the
// response beats into the queue. An unaccepted request is withdrawn on a
// soft reset or a pointer reload. Assumes at most one burst in flight and
// that soft reset is only used with no burst outstanding.
module aud_fetch_ctrl
    import aud_fetch_pkg::*;
#(
    parameter int BURST_BEATS = 16,
    parameter int FIFO_WORDS  = 32,
    localparam int LVL_W      = $clog2(FIFO_WORDS + 1),
    localparam int CNT_W      = $clog2(BURST_BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             reload,
    input  logic             run,
    input  logic [LVL_W-1:0] level,
    input  logic             req_ready,
    input  logic             rsp_valid,
    output logic             req_valid,
    output logic             push,
    output logic             burst_done
);
    localparam logic [LVL_W-1:0] ROOM_MAX = LVL_W'(FIFO_WORDS - BURST_BEATS);
    localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BURST_BEATS - 1);

    fetch_state_e     state;
    fetch_state_e     state_nx;
    logic [CNT_W-1:0] beat_cnt;
    logic             room;

    // Output decode and room test.
    always_comb begin
        room       = (level <= ROOM_MAX);
        req_valid  = (state == FS_REQ);
        push       = (state == FS_BURST) && rsp_valid;
        burst_done = push && (beat_cnt == LAST_BEAT);
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            FS_IDLE:  if (run && room && !soft_rst) state_nx = FS_REQ;
            FS_REQ: begin
                if (req_ready)                state_nx = FS_BURST;
                else if (soft_rst || reload)  state_nx = FS_IDLE;
            end
            FS_BURST: if (soft_rst || burst_done) state_nx = FS_IDLE;
            default:  state_nx = FS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= state_nx;
    end

    // Beat counter within a burst.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst || state != FS_BURST) beat_cnt <= '0;
        else if (push)                               beat_cnt <= beat_cnt + 1'b1;
    end
endmodule

// File: rtl/aud_ring_fetch.sv
// Audio ring-buffer fetch engine (top).
// Reads fixed bursts from a circular memory region into a sample queue.
// Assumes the ring base is burst aligned, the ring length is a whole
// number of bursts, cfg_end addresses the ring's last 8-byte word, and
// that pointers are reprogrammed only while no burst is outstanding.
module aud_ring_fetch #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int BURST_BEATS = 16,
    parameter int FIFO_WORDS  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              init,
    input  logic              fill_en,
    input  logic              empty_en,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [ADDR_W-1:0] cfg_end,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] rd_wdata,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              smp_valid,
    input  logic              smp_ready,
    output logic [DATA_W-1:0] smp_data
);
    localparam int BEAT_BYTES  = DATA_W / 8;
    localparam int BURST_BYTES = BEAT_BYTES * BURST_BEATS;
    localparam int LVL_W       = $clog2(FIFO_WORDS + 1);

    logic             run;
    logic             push;
    logic             burst_done;
    logic [LVL_W-1:0] fifo_level;

    // Fetch permission: both enables set and init released.
    always_comb begin
        run          = fill_en && empty_en && !init;
        mem_req_addr = rd_ptr;
    end

    aud_fetch_ptr #(
        .ADDR_W     (ADDR_W),
        .BEAT_BYTES (BEAT_BYTES),
        .BURST_BYTES(BURST_BYTES)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_base(soft_rst || init),
        .wr       (rd_wr),
        .wr_val   (rd_wdata),
        .base     (cfg_start),
        .last_word(cfg_end),
        .advance  (burst_done),
        .ptr      (rd_ptr)
    );

    aud_fetch_ctrl #(
        .BURST_BEATS(BURST_BEATS),
        .FIFO_WORDS (FIFO_WORDS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .reload    (init || rd_wr),
        .run       (run),
        .level     (fifo_level),
        .req_ready (mem_req_ready),
        .rsp_valid (mem_rsp_valid),
        .req_valid (mem_req_valid),
        .push      (push),
        .burst_done(burst_done)
    );

    aud_fetch_fifo #(
        .DATA_W(DATA_W),
        .DEPTH (FIFO_WORDS)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (soft_rst),
        .push     (push),
        .din      (mem_rsp_data),
        .pop      (smp_ready),
        .dout     (smp_data),
        .not_empty(smp_valid),
        .level    (fifo_level)
    );
endmodule

// File: rtl/aud_ring_fetch_chk.sv
// Protocol checker for the fetch engine, attached by bind.
module aud_ring_fetch_chk #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int BURST_BEATS = 16,
    parameter int FIFO_WORDS  = 32,
    localparam int LVL_W      = $clog2(FIFO_WORDS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic              init,
    input logic              fill_en,
    input logic              empty_en,
    input logic              rd_wr,
    input logic [ADDR_W-1:0] cfg_start,
    input logic [ADDR_W-1:0] rd_ptr,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              smp_valid,
    input logic              smp_ready,
    input logic [DATA_W-1:0] smp_data,
    input logic [LVL_W-1:0]  fifo_level
);
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(fill_en && empty_en && !init)); // R4

    AST_ROOM_BEFORE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> ($past(fifo_level) <= LVL_W'(FIFO_WORDS - BURST_BEATS))); // R5

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready && !soft_rst && !init && !rd_wr)
        |=> (mem_req_valid && $stable(mem_req_addr))); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(FIFO_WORDS)); // R7

    AST_SMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_ready && !soft_rst) |=> (smp_valid && $stable(smp_data))); // R7

    AST_INIT_LOADS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (rd_ptr == $past(cfg_start))); // R3

    AST_SOFT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!smp_valid && rd_ptr == $past(cfg_start))); // R8
endmodule

bind aud_ring_fetch aud_ring_fetch_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .BURST_BEATS(BURST_BEATS),
    .FIFO_WORDS (FIFO_WORDS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .init         (init),
    .fill_en      (fill_en),
    .empty_en     (empty_en),
    .rd_wr        (rd_wr),
    .cfg_start    (cfg_start),
    .rd_ptr       (rd_ptr),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .smp_valid    (smp_valid),
    .smp_ready    (smp_ready),
    .smp_data     (smp_data),
    .fifo_level   (fifo_level)
);

// File: tb/aud_ring_fetch_bench.sv
module aud_ring_fetch_bench;
    logic        clk = 1'b0;
    logic        rst_n, soft_rst, init, fill_en, empty_en, rd_wr;
    logic [31:0] cfg_start, cfg_end, rd_wdata, rd_ptr, mem_req_addr;
    logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
    logic [63:0] mem_rsp_data, smp_data;
    logic        smp_valid, smp_ready;

    always #10 clk = ~clk;

    aud_ring_fetch u_aud_ring_fetch (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .init(init),
        .fill_en(fill_en), .empty_en(empty_en), .cfg_start(cfg_start),
        .cfg_end(cfg_end), .rd_wr(rd_wr), .rd_wdata(rd_wdata), .rd_ptr(rd_ptr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .smp_valid(smp_valid),
        .smp_ready(smp_ready), .smp_data(smp_data)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // Reference model state for the memory side and the sink side.
    int          beats_left = 0, nreq = 0, nwords = 0, sink_mode = 0;
    bit          req_pend = 0, rsp_pend = 0, pop_pend = 0;
    logic [31:0] burst_addr = '0, req_cap = '0, exp_word = '0, fetch_exp = '0;
    logic [63:0] pop_cap = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_word(input logic [31:0] a);
        return (a == cfg_end) ? cfg_start : a + 32'd8;
    endfunction

    function automatic logic [31:0] next_burst(input logic [31:0] a);
        return ((a + 32'd120) == cfg_end) ? cfg_start : a + 32'd128;
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        for (int g = 0; g < 800 && quiet < 4; g++) begin
            step(1);
            if (!mem_req_valid && beats_left == 0 && !req_pend && !rsp_pend) quiet++;
            else quiet = 0;
        end
    endtask

    // Memory model and sink, acting at the falling edge.
    initial begin
        void'($urandom(32'd7719));
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0; smp_ready = 0;
        forever begin
            @(negedge clk);
            if (req_pend) begin
                burst_addr = req_cap; beats_left = 16; req_pend = 0; nreq++;
                chk(req_cap == fetch_exp, "R5/R6 request address", req_cap, fetch_exp);
                fetch_exp = next_burst(fetch_exp);
            end
            if (rsp_pend) begin
                beats_left--; burst_addr += 32'd8; rsp_pend = 0;
            end
            if (pop_pend) begin
                chk(pop_cap == {32'd0, exp_word}, "R7 sample order", pop_cap, {32'd0, exp_word});
                exp_word = next_word(exp_word); nwords++; pop_pend = 0;
            end
            mem_req_ready = mem_req_valid && beats_left == 0 && ($urandom_range(0, 9) < 7);
            if (mem_req_valid && mem_req_ready) begin req_pend = 1; req_cap = mem_req_addr; end
            mem_rsp_valid = (beats_left > 0) && ($urandom_range(0, 3) != 0);
            mem_rsp_data  = {32'd0, burst_addr};
            if (mem_rsp_valid) rsp_pend = 1;
            smp_ready = (sink_mode == 1) || (sink_mode == 2 && $urandom_range(0, 1) == 1);
            if (smp_valid && smp_ready) begin pop_pend = 1; pop_cap = smp_data; end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n0;
        rst_n = 0; soft_rst = 0; init = 0; fill_en = 0; empty_en = 0; rd_wr = 0;
        cfg_start = 32'h1000; cfg_end = 32'h11F8; rd_wdata = '0;
        step(4);
        chk(!mem_req_valid && !smp_valid, "R1 reset outputs", {mem_req_valid, smp_valid}, 0);
        chk(rd_ptr == 0, "R1 reset pointer", rd_ptr, 0);
        rst_n = 1; step(1);

        rd_wr = 1; rd_wdata = 32'h1234_5600; step(1); rd_wr = 0;
        chk(rd_ptr == 32'h1234_5600, "R2 pointer write", rd_ptr, 32'h1234_5600);

        init = 1; step(1);
        chk(rd_ptr == cfg_start, "R3 init loads base", rd_ptr, cfg_start);
        fill_en = 1; empty_en = 1; step(20);
        chk(nreq == 0 && !mem_req_valid, "R3 no request while init high", nreq, 0);
        init = 0; fill_en = 0; step(20);
        chk(nreq == 0 && !mem_req_valid, "R4 empty_en alone", nreq, 0);
        empty_en = 0; fill_en = 1; step(20);
        chk(nreq == 0 && !mem_req_valid, "R4 fill_en alone", nreq, 0);

        exp_word = cfg_start; fetch_exp = cfg_start; sink_mode = 0;
        empty_en = 1; step(300);
        chk(nreq == 2, "R5 stall on full queue", nreq, 2);
        chk(smp_valid, "R7 valid when non-empty", smp_valid, 1);
        chk(rd_ptr == cfg_start + 32'd256, "R6 advance by burst", rd_ptr, cfg_start + 32'd256);

        sink_mode = 2; step(2500);
        chk(nwords > 200, "R6 wrapping stream consumed", nwords, 200);

        sink_mode = 1;
        for (int g = 0; g < 800 && !(beats_left >= 4 && beats_left <= 12); g++) step(1);
        fill_en = 0; n0 = nreq; step(120);
        chk(beats_left == 0, "R9 burst finished", beats_left, 0);
        chk(nreq == n0, "R9 no request after disable", nreq, n0);
        chk(!smp_valid && nwords % 16 == 0, "R9 all beats queued", nwords, 0);

        sink_mode = 0; fill_en = 1; step(300);
        fill_en = 0; wait_idle();
        chk(smp_valid, "R8 queue filled before soft reset", smp_valid, 1);
        soft_rst = 1; step(1); soft_rst = 0;
        chk(!smp_valid, "R8 queue emptied", smp_valid, 0);
        chk(rd_ptr == cfg_start, "R8 pointer at base", rd_ptr, cfg_start);

        for (int it = 0; it < 6; it++) begin
            logic [31:0] b;
            sink_mode = 0; fill_en = 0; wait_idle();
            b = {$urandom_range(1, 4000), 7'd0};
            cfg_start = b;
            cfg_end = b + 32'd128 * (it % 4 + 1) - 32'd8;
            soft_rst = 1; step(1); soft_rst = 0;
            rd_wr = 1; rd_wdata = b + 32'd64; step(1); rd_wr = 0;
            init = 1; step(1); init = 0;
            chk(rd_ptr == cfg_start, "R3 init after reprogram", rd_ptr, cfg_start);
            exp_word = cfg_start; fetch_exp = cfg_start;
            sink_mode = 2; fill_en = 1; step(500);
        end
        sink_mode = 1; fill_en = 0; wait_idle(); step(40);
        chk(!smp_valid, "R7 drained at end", smp_valid, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule